// File: doc/BRIEF.md
# Multi-Stream DMA Service Arbiter

This block shares one bus master port among several peripheral-to-memory DMA streams. Software arms each stream through a shared configuration port with a data width, a service mode (one beat, or an indivisible burst of 4, 8 or 16 beats), a priority level, an item count, a destination address and a fixed peripheral address. A peripheral raises its request line. The stream then records a pending service, and the arbiter picks one pending stream at a time.

A grant covers exactly one service. That is one beat in single mode, or a whole locked burst in burst mode. After the service the arbiter chooses again, so every active stream makes progress in turn and no stream waits for another to finish its count. Each accepted beat lowers the stream's item count by one and advances its destination by the width in bytes. When the count reaches zero, the stream flags completion and stops responding to requests until it is armed again. A burst request that needs more items than remain is refused with a sticky error flag, and no beats are issued for it.

Top module: `dma_stream_arb`

## Requirements
- R1: The width field encodes the beat size: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. `bus_size` carries the raw field. `bus_dst` starts at the armed destination and advances by the byte size after each accepted beat. `bus_src` stays at the armed peripheral address.
- R2: Mode 0 (single) makes each service exactly one beat, with `bus_lock` low and `bus_last` high.
- R3: Modes 1, 2 and 3 make each service 4, 8 and 16 beats respectively. `bus_last` is high only on the final beat of a service.
- R4: During a burst, `bus_lock` is high on every beat. `bus_stream` cannot change until the final beat has been accepted.
- R5: The bytes moved for a stream equal its armed item count times its byte size, in every mode.
- R6: The item count drops by one per accepted beat. At zero, `xfer_done` rises and stays high. Requests on that stream then produce no beats until it is armed again.
- R7: Among pending streams, the highest priority value wins. Ties go round-robin, starting at the stream after the one last chosen. An active stream is served between the services of others and does not wait for their completion.
- R8: A burst-mode pending request with fewer items remaining than the burst length sets the stream's sticky `cfg_err`, drops the request, and produces no beat.
- R9: While `bus_ready` is low, `bus_valid`, `bus_stream`, `bus_dst` and `bus_lock` hold. The beat count of a service is unaffected by stalls.
- R10: After reset, `bus_valid`, `bus_lock`, `bus_last`, `xfer_done` and `cfg_err` are low. A request driven before edge k becomes pending at edge k. It is granted at edge k+1, so the first beat is valid after edge k+1. One idle cycle separates consecutive services.
- R11: An arm pulse loads the configuration and clears the stream's done, error and pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_valid | input | 1 | Arm pulse for stream `arm_id` |
| arm_id | input | SID_W | Stream being armed |
| arm_width | input | 2 | Beat width code |
| arm_mode | input | 2 | 0 single, 1/2/3 burst of 4/8/16 |
| arm_prio | input | PRIO_W | Priority level, larger wins |
| arm_count | input | CNT_W | Items to move |
| arm_dst | input | ADDR_W | Memory start address |
| arm_src | input | ADDR_W | Fixed peripheral address |
| req | input | NUM_STREAMS | Peripheral service requests |
| bus_valid | output | 1 | Beat offered |
| bus_ready | input | 1 | Beat accepted when high with valid |
| bus_lock | output | 1 | Burst in progress, do not degrant |
| bus_last | output | 1 | Final beat of the current service |
| bus_stream | output | SID_W | Stream owning the beat |
| bus_size | output | 2 | Width code of the beat |
| bus_src | output | ADDR_W | Peripheral address |
| bus_dst | output | ADDR_W | Memory address of the beat |
| xfer_done | output | NUM_STREAMS | Per-stream completion flags |
| cfg_err | output | NUM_STREAMS | Per-stream burst-length error flags |

## Verification
A request is pending one edge after it is driven, and it is granted on the following edge, so its first beat appears two edges after the request. The done flag and the destination step appear on the edge that accepts the beat, and the error flag appears on the edge where the arbiter refuses the stream. The bench steps a behavioural model on each rising edge from the same inputs, applying these latencies. It compares every output on the falling edge, after all registers have settled. Directed checks target the request-to-beat latency, the completion order under interleaving and priority, the refused burst, and the byte totals.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int BEAT_W = 5;

  localparam logic [1:0] MODE_SINGLE  = 2'd0;
  localparam logic [1:0] MODE_BURST4  = 2'd1;
  localparam logic [1:0] MODE_BURST8  = 2'd2;

  // byte size of one beat from the width code
  function automatic logic [2:0] width_bytes(input logic [1:0] w);
    case (w)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // beats per service from the mode code
  function automatic logic [BEAT_W-1:0] mode_beats(input logic [1:0] m);
    case (m)
      MODE_SINGLE: return 5'd1;
      MODE_BURST4: return 5'd4;
      MODE_BURST8: return 5'd8;
      default:     return 5'd16;
    endcase
  endfunction

  function automatic logic mode_locks(input logic [1:0] m);
    return m != MODE_SINGLE;
  endfunction

endpackage

// File: rtl/dma_stream_ctx.sv
module dma_stream_ctx
  import dma_arb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [1:0]        arm_width,
  input  logic [1:0]        arm_mode,
  input  logic [PRIO_W-1:0] arm_prio,
  input  logic [CNT_W-1:0]  arm_count,
  input  logic [ADDR_W-1:0] arm_dst,
  input  logic [ADDR_W-1:0] arm_src,
  input  logic              req,
  input  logic              beat,
  input  logic              svc_end,
  input  logic              err_set,
  output logic              pending,
  output logic              done,
  output logic              err,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] dst,
  output logic [ADDR_W-1:0] src,
  output logic [1:0]        width,
  output logic [1:0]        mode,
  output logic [PRIO_W-1:0] prio
);

  logic armed;
  logic live;
  logic last_item;

  assign live      = armed & ~done;
  assign last_item = beat && (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      pending <= 1'b0;
      count   <= '0;
      dst     <= '0;
      src     <= '0;
      width   <= '0;
      mode    <= '0;
      prio    <= '0;
    end else if (arm) begin
      armed   <= 1'b1;
      done    <= (arm_count == '0);
      err     <= 1'b0;
      pending <= 1'b0;
      count   <= arm_count;
      dst     <= arm_dst;
      src     <= arm_src;
      width   <= arm_width;
      mode    <= arm_mode;
      prio    <= arm_prio;
    end else begin
      if (beat) begin
        count <= count - CNT_W'(1);
        dst   <= dst + ADDR_W'(width_bytes(width));
      end
      if (last_item) done <= 1'b1;
      if (err_set)   err  <= 1'b1;
      // a fresh request survives the end of the service it overlaps
      if (last_item)         pending <= 1'b0;
      else if (req && live)  pending <= 1'b1;
      else if (svc_end)      pending <= 1'b0;
    end
  end

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (count == '0)); // R6
  AST_BEAT_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (live && count != '0)); // R6
  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |-> !beat); // R8

endmodule

// File: rtl/dma_rr_pick.sv
module dma_rr_pick #(
  parameter  int N      = 4,
  parameter  int PRIO_W = 2,
  localparam int SID_W  = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      pend,
  input  logic [PRIO_W-1:0] prio [N],
  input  logic [SID_W-1:0]  last_id,
  output logic              pick_valid,
  output logic [SID_W-1:0]  pick_id
);

  logic [PRIO_W-1:0] best_prio;
  logic [SID_W-1:0]  sel;
  int                idx;

  // scan in round-robin order; strict compare keeps the earliest tie
  always_comb begin
    pick_valid = 1'b0;
    pick_id    = '0;
    best_prio  = '0;
    sel        = '0;
    idx        = 0;
    for (int off = 1; off <= N; off++) begin
      idx = (int'(last_id) + off) % N;
      sel = SID_W'(idx);
      if (pend[sel] && (!pick_valid || prio[sel] > best_prio)) begin
        pick_valid = 1'b1;
        pick_id    = sel;
        best_prio  = prio[sel];
      end
    end
  end

  AST_PICK_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> pend[pick_id]); // R7
  AST_PICK_WHEN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> pick_valid); // R7

endmodule

// File: rtl/dma_beat_engine.sv
module dma_beat_engine
  import dma_arb_pkg::*;
#(
  parameter  int N     = 4,
  parameter  int CNT_W = 16,
  localparam int SID_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pick_valid,
  input  logic [SID_W-1:0] pick_id,
  input  logic [1:0]       pick_mode,
  input  logic [CNT_W-1:0] pick_count,
  input  logic             bus_ready,
  output logic             busy,
  output logic             lock,
  output logic             last,
  output logic [SID_W-1:0] cur_id,
  output logic [SID_W-1:0] last_id,
  output logic             beat_fire,
  output logic             err_fire,
  output logic             grant_fire
);

  logic [BEAT_W-1:0] left;
  logic [BEAT_W-1:0] need;
  logic              fits;

  assign need       = mode_beats(pick_mode);
  assign fits       = (pick_mode == MODE_SINGLE) || (pick_count >= CNT_W'(need));
  assign grant_fire = !busy && pick_valid && fits;
  assign err_fire   = !busy && pick_valid && !fits;
  assign beat_fire  = busy && bus_ready;
  assign last       = busy && (left == BEAT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      lock    <= 1'b0;
      left    <= '0;
      cur_id  <= '0;
      last_id <= '0;
    end else if (grant_fire) begin
      busy    <= 1'b1;
      lock    <= mode_locks(pick_mode);
      left    <= need;
      cur_id  <= pick_id;
      last_id <= pick_id;
    end else if (err_fire) begin
      last_id <= pick_id;
    end else if (beat_fire) begin
      left <= left - BEAT_W'(1);
      if (last) begin
        busy <= 1'b0;
        lock <= 1'b0;
      end
    end
  end

  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lock && !(bus_ready && last)) |=> (busy && lock && $stable(cur_id))); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_ready) |=> (busy && $stable(cur_id) && $stable(left) && $stable(lock))); // R9
  AST_ERR_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    err_fire |=> !busy); // R8
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && last) |=> !busy); // R10

endmodule

// File: rtl/dma_stream_arb.sv
module dma_stream_arb
  import dma_arb_pkg::*;
#(
  parameter  int NUM_STREAMS = 4,
  parameter  int CNT_W       = 16,
  parameter  int ADDR_W      = 32,
  parameter  int PRIO_W      = 2,
  localparam int SID_W       = $clog2(NUM_STREAMS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arm_valid,
  input  logic [SID_W-1:0]       arm_id,
  input  logic [1:0]             arm_width,
  input  logic [1:0]             arm_mode,
  input  logic [PRIO_W-1:0]      arm_prio,
  input  logic [CNT_W-1:0]       arm_count,
  input  logic [ADDR_W-1:0]      arm_dst,
  input  logic [ADDR_W-1:0]      arm_src,
  input  logic [NUM_STREAMS-1:0] req,
  output logic                   bus_valid,
  input  logic                   bus_ready,
  output logic                   bus_lock,
  output logic                   bus_last,
  output logic [SID_W-1:0]       bus_stream,
  output logic [1:0]             bus_size,
  output logic [ADDR_W-1:0]      bus_src,
  output logic [ADDR_W-1:0]      bus_dst,
  output logic [NUM_STREAMS-1:0] xfer_done,
  output logic [NUM_STREAMS-1:0] cfg_err
);

  logic [NUM_STREAMS-1:0] pend_v;
  logic [CNT_W-1:0]       cnt_a   [NUM_STREAMS];
  logic [ADDR_W-1:0]      dst_a   [NUM_STREAMS];
  logic [ADDR_W-1:0]      src_a   [NUM_STREAMS];
  logic [1:0]             width_a [NUM_STREAMS];
  logic [1:0]             mode_a  [NUM_STREAMS];
  logic [PRIO_W-1:0]      prio_a  [NUM_STREAMS];

  logic             pick_valid;
  logic [SID_W-1:0] pick_id;
  logic [SID_W-1:0] cur_id;
  logic [SID_W-1:0] last_id;
  logic             busy;
  logic             lock;
  logic             last;
  logic             beat_fire;
  logic             err_fire;
  logic             grant_fire;

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
    logic arm_g;
    logic beat_g;
    logic err_g;
    logic end_g;

    assign arm_g  = arm_valid && (arm_id == SID_W'(g));
    assign beat_g = beat_fire && (cur_id == SID_W'(g));
    assign err_g  = err_fire && (pick_id == SID_W'(g));
    assign end_g  = (beat_g && last) || err_g;

    dma_stream_ctx #(
      .CNT_W (CNT_W),
      .ADDR_W(ADDR_W),
      .PRIO_W(PRIO_W)
    ) u_ctx (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm_g),
      .arm_width(arm_width),
      .arm_mode (arm_mode),
      .arm_prio (arm_prio),
      .arm_count(arm_count),
      .arm_dst  (arm_dst),
      .arm_src  (arm_src),
      .req      (req[g]),
      .beat     (beat_g),
      .svc_end  (end_g),
      .err_set  (err_g),
      .pending  (pend_v[g]),
      .done     (xfer_done[g]),
      .err      (cfg_err[g]),
      .count    (cnt_a[g]),
      .dst      (dst_a[g]),
      .src      (src_a[g]),
      .width    (width_a[g]),
      .mode     (mode_a[g]),
      .prio     (prio_a[g])
    );
  end

  dma_rr_pick #(
    .N     (NUM_STREAMS),
    .PRIO_W(PRIO_W)
  ) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend_v),
    .prio      (prio_a),
    .last_id   (last_id),
    .pick_valid(pick_valid),
    .pick_id   (pick_id)
  );

  dma_beat_engine #(
    .N    (NUM_STREAMS),
    .CNT_W(CNT_W)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick_valid(pick_valid),
    .pick_id   (pick_id),
    .pick_mode (mode_a[pick_id]),
    .pick_count(cnt_a[pick_id]),
    .bus_ready (bus_ready),
    .busy      (busy),
    .lock      (lock),
    .last      (last),
    .cur_id    (cur_id),
    .last_id   (last_id),
    .beat_fire (beat_fire),
    .err_fire  (err_fire),
    .grant_fire(grant_fire)
  );

  assign bus_valid  = busy;
  assign bus_lock   = lock;
  assign bus_last   = last;
  assign bus_stream = cur_id;
  assign bus_size   = width_a[cur_id];
  assign bus_src    = src_a[cur_id];
  assign bus_dst    = dst_a[cur_id];

  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_last)
      |=> (bus_dst == $past(bus_dst) + ADDR_W'(width_bytes($past(bus_size))))); // R1
  AST_GRANT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |=> (bus_valid && bus_stream == $past(pick_id))); // R10
  AST_SINGLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_lock) |-> bus_last); // R2

endmodule

// File: tb/tb_dma_stream_arb.sv
module tb_dma_stream_arb;

  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm_valid = 1'b0;
  logic [1:0]  arm_id = '0;
  logic [1:0]  arm_width = '0;
  logic [1:0]  arm_mode = '0;
  logic [1:0]  arm_prio = '0;
  logic [15:0] arm_count = '0;
  logic [31:0] arm_dst = '0;
  logic [31:0] arm_src = '0;
  logic [3:0]  req = '0;
  logic        bus_valid;
  logic        bus_ready = 1'b1;
  logic        bus_lock;
  logic        bus_last;
  logic [1:0]  bus_stream;
  logic [1:0]  bus_size;
  logic [31:0] bus_src;
  logic [31:0] bus_dst;
  logic [3:0]  xfer_done;
  logic [3:0]  cfg_err;

  dma_stream_arb dut (
    .clk(clk), .rst_n(rst_n), .arm_valid(arm_valid), .arm_id(arm_id),
    .arm_width(arm_width), .arm_mode(arm_mode), .arm_prio(arm_prio),
    .arm_count(arm_count), .arm_dst(arm_dst), .arm_src(arm_src), .req(req),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_lock(bus_lock),
    .bus_last(bus_last), .bus_stream(bus_stream), .bus_size(bus_size),
    .bus_src(bus_src), .bus_dst(bus_dst), .xfer_done(xfer_done), .cfg_err(cfg_err)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mdl_on = 1'b0;
  bit stall_en = 1'b0;
  int bacc [NS];

  // behavioural model state
  int m_arm [NS], m_done [NS], m_err [NS], m_pend [NS];
  int m_cnt [NS], m_w [NS], m_mode [NS], m_prio [NS];
  logic [31:0] m_dst [NS], m_src [NS];
  int m_busy, m_cur, m_left, m_last, m_lock;
  int t_live [NS];
  int t_pk, t_fits, t_beat, t_c, t_b, t_e, t_end, t_zero;

  function automatic int nbytes(input int w);
    return (w >= 2) ? 4 : (1 << w);
  endfunction

  function automatic int nbeats(input int md);
    return (md == 0) ? 1 : (2 << md);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog cycles=%0d expected<=%0d", cyc, 50000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        m_arm[i] = 0; m_done[i] = 0; m_err[i] = 0; m_pend[i] = 0;
        m_cnt[i] = 0; m_w[i] = 0; m_mode[i] = 0; m_prio[i] = 0;
        m_dst[i] = '0; m_src[i] = '0;
      end
      m_busy = 0; m_cur = 0; m_left = 0; m_last = 0; m_lock = 0;
    end else begin
      for (int i = 0; i < NS; i++) t_live[i] = m_arm[i] && !m_done[i];
      t_beat = m_busy && bus_ready;
      t_c = m_cur;
      t_pk = -1;
      t_fits = 0;
      if (!m_busy) begin
        for (int off = 1; off <= NS; off++) begin
          int i;
          i = (m_last + off) % NS;
          if (m_pend[i] != 0 && (t_pk < 0 || m_prio[i] > m_prio[t_pk])) t_pk = i;
        end
        if (t_pk >= 0) t_fits = (m_mode[t_pk] == 0) || (m_cnt[t_pk] >= nbeats(m_mode[t_pk]));
      end
      for (int i = 0; i < NS; i++) begin
        if (arm_valid && int'(arm_id) == i) begin
          m_arm[i] = 1; m_done[i] = (arm_count == 0); m_err[i] = 0; m_pend[i] = 0;
          m_cnt[i] = int'(arm_count); m_w[i] = int'(arm_width); m_mode[i] = int'(arm_mode);
          m_prio[i] = int'(arm_prio); m_dst[i] = arm_dst; m_src[i] = arm_src;
        end else begin
          t_b = t_beat && (t_c == i);
          t_e = (t_pk == i) && !t_fits;
          t_end = (t_b && m_left == 1) || t_e;
          t_zero = t_b && (m_cnt[i] == 1);
          if (t_b) begin
            m_cnt[i] = m_cnt[i] - 1;
            m_dst[i] = m_dst[i] + 32'(nbytes(m_w[i]));
          end
          if (t_zero) m_done[i] = 1;
          if (t_e) m_err[i] = 1;
          if (t_zero) m_pend[i] = 0;
          else if (req[i] && t_live[i] != 0) m_pend[i] = 1;
          else if (t_end) m_pend[i] = 0;
        end
      end
      if (t_beat) begin
        m_left = m_left - 1;
        if (m_left == 0) begin m_busy = 0; m_lock = 0; end
      end else if (t_pk >= 0) begin
        m_last = t_pk;
        if (t_fits) begin
          m_busy = 1; m_cur = t_pk; m_left = nbeats(m_mode[t_pk]);
          m_lock = (m_mode[t_pk] != 0);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (mdl_on) begin
      chk(bus_valid == (m_busy != 0), "R10 R9 bus_valid", bus_valid, m_busy);
      if (m_busy != 0) begin
        chk(bus_lock == (m_lock != 0), "R2 R4 bus_lock", bus_lock, m_lock);
        chk(bus_last == (m_left == 1), "R3 bus_last", bus_last, m_left == 1);
        chk(int'(bus_stream) == m_cur, "R7 R4 bus_stream", bus_stream, m_cur);
        chk(bus_dst == m_dst[m_cur], "R1 R9 bus_dst", bus_dst, m_dst[m_cur]);
        chk(int'(bus_size) == m_w[m_cur], "R1 bus_size", bus_size, m_w[m_cur]);
        chk(bus_src == m_src[m_cur], "R1 bus_src", bus_src, m_src[m_cur]);
      end
      for (int i = 0; i < NS; i++) begin
        chk(xfer_done[i] == (m_done[i] != 0), "R6 xfer_done", xfer_done[i], m_done[i]);
        chk(cfg_err[i] == (m_err[i] != 0), "R8 cfg_err", cfg_err[i], m_err[i]);
      end
    end
    bus_ready = stall_en ? (($urandom % 4) != 0) : 1'b1;
    if (bus_valid && bus_ready) bacc[bus_stream] += nbytes(int'(bus_size));
  end

  task automatic arm_stream(input int id, input int w, input int md, input int pr,
                            input int cnt, input logic [31:0] d, input logic [31:0] s);
    arm_valid = 1'b1; arm_id = 2'(id); arm_width = 2'(w); arm_mode = 2'(md);
    arm_prio = 2'(pr); arm_count = 16'(cnt); arm_dst = d; arm_src = s;
    @(negedge clk);
    arm_valid = 1'b0;
  endtask

  task automatic wait_done(input int id, input int lim);
    for (int k = 0; k < lim && !xfer_done[id]; k++) @(negedge clk);
  endtask

  task automatic clear_acc();
    for (int i = 0; i < NS; i++) bacc[i] = 0;
  endtask

  initial begin
    clear_acc();
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(bus_valid == 1'b0, "R10 reset bus_valid", bus_valid, 0);
    chk(bus_lock == 1'b0 && bus_last == 1'b0, "R10 reset lock/last", {bus_lock, bus_last}, 0);
    chk(xfer_done == 4'h0, "R10 reset xfer_done", xfer_done, 0);
    chk(cfg_err == 4'h0, "R10 reset cfg_err", cfg_err, 0);
    rst_n = 1'b1;
    mdl_on = 1'b1;
    @(negedge clk);

    // Phase A: equal priority singles interleave (R7, R5, R2)
    arm_stream(0, 0, 0, 0, 6,  32'h1000, 32'h4000_0000);
    arm_stream(1, 1, 0, 0, 2,  32'h2000, 32'h4000_0100);
    arm_stream(2, 2, 0, 0, 20, 32'h3000, 32'h4000_0200);
    req = 4'b0111;
    wait_done(1, 200);
    chk(xfer_done[1] && !xfer_done[0] && !xfer_done[2], "R7 stream1 done while others active",
        xfer_done, 4'b0010);
    wait_done(0, 200);
    chk(!xfer_done[2], "R7 stream0 done before stream2", xfer_done[2], 0);
    wait_done(2, 400);
    req = 4'b0000;
    chk(bacc[0] == 6,  "R5 stream0 bytes", bacc[0], 6);
    chk(bacc[1] == 4,  "R5 stream1 bytes", bacc[1], 4);
    chk(bacc[2] == 80, "R5 stream2 bytes", bacc[2], 80);
    repeat (3) @(negedge clk);

    // Phase B: bursts under stalls (R3, R4, R9, R5)
    clear_acc();
    stall_en = 1'b1;
    arm_stream(3, 2, 2, 0, 16, 32'h5000, 32'h4000_0300);
    arm_stream(0, 1, 1, 0, 8,  32'h6000, 32'h4000_0000);
    req = 4'b1001;
    wait_done(3, 1000);
    wait_done(0, 1000);
    req = 4'b0000;
    chk(xfer_done[3] && xfer_done[0], "R3 bursts complete", {xfer_done[3], xfer_done[0]}, 3);
    chk(bacc[3] == 64, "R5 stream3 burst8 bytes", bacc[3], 64);
    chk(bacc[0] == 16, "R5 stream0 burst4 bytes", bacc[0], 16);
    stall_en = 1'b0;
    repeat (3) @(negedge clk);

    // Phase C: priority (R7)
    clear_acc();
    arm_stream(1, 0, 0, 0, 10, 32'h7000, 32'h4000_0100);
    arm_stream(2, 0, 0, 3, 4,  32'h8000, 32'h4000_0200);
    req = 4'b0110;
    wait_done(2, 200);
    chk(xfer_done[2] && bacc[1] == 0, "R7 high priority served first", bacc[1], 0);
    wait_done(1, 200);
    req = 4'b0000;
    chk(bacc[1] == 10 && bacc[2] == 4, "R5 priority phase bytes", bacc[1] * 256 + bacc[2], 10 * 256 + 4);
    repeat (3) @(negedge clk);

    // Phase D: burst longer than remaining items (R8)
    clear_acc();
    arm_stream(3, 0, 3, 0, 5, 32'h9000, 32'h4000_0300);
    req[3] = 1'b1;
    @(negedge clk);
    req[3] = 1'b0;
    repeat (5) @(negedge clk);
    chk(cfg_err[3] == 1'b1, "R8 error flag raised", cfg_err[3], 1);
    chk(bacc[3] == 0, "R8 no beats for refused burst", bacc[3], 0);
    chk(bus_valid == 1'b0, "R8 bus idle after refusal", bus_valid, 0);

    // Phase E: done stream ignores requests (R6)
    clear_acc();
    req[1] = 1'b1;
    repeat (3) @(negedge clk);
    req[1] = 1'b0;
    repeat (4) @(negedge clk);
    chk(bacc[1] == 0 && xfer_done[1], "R6 done stream ignores requests", bacc[1], 0);

    // Phase F: re-arm clears flags, request-to-beat latency (R11, R10)
    clear_acc();
    arm_stream(3, 2, 0, 1, 3, 32'hA000, 32'h4000_0300);
    chk(cfg_err[3] == 1'b0 && xfer_done[3] == 1'b0, "R11 re-arm clears flags",
        {cfg_err[3], xfer_done[3]}, 0);
    req[3] = 1'b1;
    @(negedge clk);
    chk(bus_valid == 1'b0, "R10 no beat one edge after request", bus_valid, 0);
    @(negedge clk);
    chk(bus_valid && bus_stream == 2'd3, "R10 beat two edges after request", bus_valid, 1);
    chk(bus_dst == 32'hA000, "R1 first beat at armed address", bus_dst, 32'hA000);
    wait_done(3, 100);
    req = 4'b0000;
    chk(bacc[3] == 12, "R5 re-armed stream bytes", bacc[3], 12);
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule